// File: doc/BRIEF.md
# Three-Operand Logic and Shift Unit

This block evaluates the Boolean and bit-shift operations of a three-register instruction class. Each operation reads two 32-bit sources, `b` and `c`, and writes one 32-bit result for the destination register `a`. The operation is picked by a 12-bit extended operation code. In the instruction word this code sits between the 8-bit primary opcode 0x05 and the three 4-bit register indices. The high eight bits of the code select the group: 0x02 is the logic group and 0x03 is the shift group. The low four bits select the function within that group.

The logic group offers ten two-input functions. Six are the familiar gates. The other four are the implication and nonimplication forms. The shift group offers eight variants:
- arithmetic shifts left and right,
- zero-filling shifts left and right,
- one-filling shifts left and right,
- circular rotates left and right.

Any code the unit does not implement raises an illegal flag and returns a zero result. The decode step, which sits around this block, uses that flag to raise an illegal-instruction trap.

The arithmetic itself is combinational. The result, the illegal flag and a valid strobe are registered, so an operation presented with `in_valid` in one cycle shows on the outputs after the next rising clock edge.

Top module: `logshift_unit`

## Requirements
- R1: After a synchronous reset, `out_valid`, `out_result` and `out_illegal` are all 0.
- R2: An operation accepted with `in_valid`=1 at a rising edge appears on `out_result`/`out_illegal` with `out_valid`=1 right after that same edge, that is, one cycle of latency.
- R3: Codes 0x020, 0x021, 0x022, 0x023, 0x024 and 0x025 give b AND c, b OR c, b XOR c, NOT(b AND c), NOT(b OR c) and NOT(b XOR c), bitwise.
- R4: Code 0x026 gives (~b & c), 0x027 gives (b & ~c), 0x028 gives (~b | c) and 0x029 gives (b | ~c).
- R5: Codes 0x02A to 0x02F, and every code outside the ranges 0x020–0x029 and 0x030–0x037, set `out_illegal`=1 and `out_result`=0.
- R6: Every code in 0x020–0x029 and 0x030–0x037 gives `out_illegal`=0.
- R7: Code 0x032 shifts b left and 0x033 shifts b right by the full unsigned value of c, filling with zeros. An amount of 32 or more gives 0.
- R8: Code 0x030 gives the same result as 0x032. Code 0x031 shifts b right by c, filling with copies of b[31]. An amount of 32 or more gives 32 copies of b[31].
- R9: Code 0x034 shifts b left and 0x035 shifts b right by c, filling the vacated positions with ones. An amount of 32 or more gives all ones.
- R10: Code 0x036 rotates b left and 0x037 rotates b right by c[4:0]. The upper bits of c are ignored.
- R11: A cycle with `in_valid`=0 gives `out_valid`=0 after the edge and leaves `out_result` and `out_illegal` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| xop | input | 12 | Extended operation code |
| src_b | input | 32 | First source value (b) |
| src_c | input | 32 | Second source value or shift amount (c) |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 32 | Registered result for destination a |
| out_illegal | output | 1 | Registered flag for an unimplemented code |

## Verification
The assertions assume that `in_valid`, `xop`, `src_b` and `src_c` are stable across each rising edge. They also assume that reset is held for at least one edge before the first operation, so that `$past` of an input always refers to a cycle that was sampled after reset. The bench changes every input only on the falling edge and keeps `in_valid` low throughout reset. Shift amounts are chosen on both sides of the 32-bit boundary. These include 31, 32, 33 and all-ones, and for rotates, values whose low five bits differ from the full value. The fill rules and the masking of c are therefore each exercised where they matter.

// File: rtl/logshift_pkg.sv
package logshift_pkg;
  localparam logic [7:0] GRP_LOGIC = 8'h02;
  localparam logic [7:0] GRP_SHIFT = 8'h03;

  typedef enum logic [3:0] {
    LF_AND   = 4'h0,
    LF_OR    = 4'h1,
    LF_XOR   = 4'h2,
    LF_NAND  = 4'h3,
    LF_NOR   = 4'h4,
    LF_XNOR  = 4'h5,
    LF_NBAC  = 4'h6,
    LF_BANC  = 4'h7,
    LF_NBOC  = 4'h8,
    LF_BONC  = 4'h9
  } lfn_e;

  typedef enum logic [3:0] {
    SF_ASL = 4'h0,
    SF_ASR = 4'h1,
    SF_ZSL = 4'h2,
    SF_ZSR = 4'h3,
    SF_OSL = 4'h4,
    SF_OSR = 4'h5,
    SF_ROL = 4'h6,
    SF_ROR = 4'h7
  } sfn_e;
endpackage

// File: rtl/logshift_bool.sv
module logshift_bool #(
  parameter int W = 32
) (
  input  logic [3:0]   fn,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y,
  output logic         ok
);
  import logshift_pkg::*;

  always_comb begin
    ok = 1'b1;
    case (lfn_e'(fn))
      LF_AND:  y = b & c;
      LF_OR:   y = b | c;
      LF_XOR:  y = b ^ c;
      LF_NAND: y = ~(b & c);
      LF_NOR:  y = ~(b | c);
      LF_XNOR: y = ~(b ^ c);
      LF_NBAC: y = ~b & c;
      LF_BANC: y = b & ~c;
      LF_NBOC: y = ~b | c;
      LF_BONC: y = b | ~c;
      default: begin
        y  = '0;
        ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/logshift_shift.sv
module logshift_shift #(
  parameter int W = 32
) (
  input  logic [3:0]   fn,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y,
  output logic         ok
);
  import logshift_pkg::*;

  localparam int SHW = $clog2(W);

  logic [SHW-1:0] amt;
  logic           over;
  logic [W-1:0]   ones;
  logic [W-1:0]   zsl, zsr, osl, osr, asr, rol, ror;
  logic [2*W-1:0] dbl_l, dbl_r;

  assign amt   = c[SHW-1:0];
  assign over  = |c[W-1:SHW];
  assign ones  = '1;
  assign dbl_l = {b, b} << amt;
  assign dbl_r = {b, b} >> amt;

  always_comb begin
    zsl = b << amt;
    zsr = b >> amt;
    osl = zsl | ~(ones << amt);
    osr = zsr | ~(ones >> amt);
    asr = W'($signed(b) >>> amt);
    rol = dbl_l[2*W-1:W];
    ror = dbl_r[W-1:0];
    if (over) begin
      zsl = '0;
      zsr = '0;
      osl = '1;
      osr = '1;
      asr = {W{b[W-1]}};
    end
  end

  always_comb begin
    ok = 1'b1;
    case (sfn_e'(fn))
      SF_ASL, SF_ZSL: y = zsl;
      SF_ASR:         y = asr;
      SF_ZSR:         y = zsr;
      SF_OSL:         y = osl;
      SF_OSR:         y = osr;
      SF_ROL:         y = rol;
      SF_ROR:         y = ror;
      default: begin
        y  = '0;
        ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/logshift_unit.sv
module logshift_unit #(
  parameter int W  = 32,
  parameter int XW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [XW-1:0] xop,
  input  logic [W-1:0]  src_b,
  input  logic [W-1:0]  src_c,
  output logic          out_valid,
  output logic [W-1:0]  out_result,
  output logic          out_illegal
);
  import logshift_pkg::*;

  localparam int GW = XW - 4;

  logic [GW-1:0] grp;
  logic [3:0]    fn;
  logic [W-1:0]  bool_y, shf_y, nxt_y;
  logic          bool_ok, shf_ok, is_bool, is_shf, legal;

  assign grp     = xop[XW-1:4];
  assign fn      = xop[3:0];
  assign is_bool = (grp == GW'(GRP_LOGIC));
  assign is_shf  = (grp == GW'(GRP_SHIFT));

  logshift_bool #(.W(W)) u_bool (
    .fn(fn), .b(src_b), .c(src_c), .y(bool_y), .ok(bool_ok)
  );

  logshift_shift #(.W(W)) u_shift (
    .fn(fn), .b(src_b), .c(src_c), .y(shf_y), .ok(shf_ok)
  );

  assign legal = (is_bool & bool_ok) | (is_shf & shf_ok);
  assign nxt_y = !legal ? '0 : (is_bool ? bool_y : shf_y);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= nxt_y;
        out_illegal <= ~legal;
      end
    end
  end
endmodule

// File: rtl/logshift_unit_chk.sv
module logshift_unit_chk #(
  parameter int W  = 32,
  parameter int XW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [XW-1:0] xop,
  input logic [W-1:0]  src_b,
  input logic [W-1:0]  src_c,
  input logic          out_valid,
  input logic [W-1:0]  out_result,
  input logic          out_illegal
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_illegal && out_result == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_illegal)));

  // R5
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_result == '0));

  // R5
  reserved_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && xop[XW-1:4] == 'h02 && xop[3:0] >= 4'hA) |=> out_illegal);

  // R4
  impl_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && xop == 'h028) |=> (out_result == ($past(src_c) | ~$past(src_b))));

  // R10
  rotate_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (xop == 'h036 || xop == 'h037)) |=>
      ($countones(out_result) == $countones($past(src_b)) && !out_illegal));

  // R9
  onefill_over_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (xop == 'h034 || xop == 'h035) && src_c >= W) |=> (&out_result));
endmodule

bind logshift_unit logshift_unit_chk #(.W(W), .XW(XW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .xop(xop), .src_b(src_b),
  .src_c(src_c), .out_valid(out_valid), .out_result(out_result),
  .out_illegal(out_illegal)
);

// File: tb/logshift_unit_test.sv
module logshift_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [11:0] xop;
  logic [31:0] src_b, src_c;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_illegal;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done  = 0;

  typedef struct {
    logic [31:0] r;
    logic        ill;
    logic [11:0] op;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  logshift_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .xop(xop), .src_b(src_b),
    .src_c(src_c), .out_valid(out_valid), .out_result(out_result),
    .out_illegal(out_illegal)
  );

  function automatic string tag_of(input logic [11:0] op);
    if (op >= 12'h020 && op <= 12'h025) return "R3";
    if (op >= 12'h026 && op <= 12'h029) return "R4";
    if (op == 12'h032 || op == 12'h033) return "R7";
    if (op == 12'h030 || op == 12'h031) return "R8";
    if (op == 12'h034 || op == 12'h035) return "R9";
    if (op == 12'h036 || op == 12'h037) return "R10";
    return "R5";
  endfunction

  function automatic void model(input logic [11:0] op, input logic [31:0] b,
                                input logic [31:0] c, output logic [31:0] r,
                                output logic ill);
    int n;
    int k;
    n = (c >= 32) ? 32 : int'(c);
    k = int'(c[4:0]);
    r = '0;
    ill = 1'b0;
    case (op)
      12'h020: r = b & c;
      12'h021: r = b | c;
      12'h022: r = b ^ c;
      12'h023: r = ~(b & c);
      12'h024: r = ~(b | c);
      12'h025: r = ~(b ^ c);
      12'h026: r = ~b & c;
      12'h027: r = b & ~c;
      12'h028: r = ~b | c;
      12'h029: r = b | ~c;
      12'h030, 12'h032:
        for (int i = 0; i < 32; i++) r[i] = (i >= n) ? b[i-n] : 1'b0;
      12'h031:
        for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? b[i+n] : b[31];
      12'h033:
        for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? b[i+n] : 1'b0;
      12'h034:
        for (int i = 0; i < 32; i++) r[i] = (i >= n) ? b[i-n] : 1'b1;
      12'h035:
        for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? b[i+n] : 1'b1;
      12'h036:
        for (int i = 0; i < 32; i++) r[i] = b[(i - k + 32) % 32];
      12'h037:
        for (int i = 0; i < 32; i++) r[i] = b[(i + k) % 32];
      default: ill = 1'b1;
    endcase
  endfunction

  // driver: inputs change on the falling edge, expected item queued
  task automatic drive(input logic [11:0] op, input logic [31:0] b, input logic [31:0] c);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    xop = op;
    src_b = b;
    src_c = c;
    model(op, b, c, e.r, e.ill);
    e.op = op;
    e.tag = tag_of(op);
    sbq.push_back(e);
  endtask

  // monitor: outputs settle after the rising edge; compare on the falling edge
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      exp_t e;
      total++;
      if (sbq.size() == 0) begin
        bad++;
        $display("FAIL R2: out_valid with empty scoreboard, actual=1 expected=0");
      end else begin
        e = sbq.pop_front();
        if (out_result !== e.r || out_illegal !== e.ill) begin
          bad++;
          $display("FAIL %s (R6 flag) op=%h: actual result=%h ill=%b expected result=%h ill=%b",
                   e.tag, e.op, out_result, out_illegal, e.r, e.ill);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [31:0] pats [6];
  logic [31:0] amts [9];

  initial begin
    logic [31:0] held_r;
    logic        held_i;
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0001;
    pats[3] = 32'h1234_5678; pats[4] = 32'hF0F0_A55A; pats[5] = 32'h7FFF_FFFE;
    amts[0] = 0; amts[1] = 1; amts[2] = 5; amts[3] = 31; amts[4] = 32;
    amts[5] = 33; amts[6] = 32'hFFFF_FFFF; amts[7] = 32'h0000_0105; amts[8] = 37;

    rst = 1'b1; in_valid = 1'b0; xop = '0; src_b = '0; src_c = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    total++;
    if (out_valid !== 1'b0 || out_result !== 32'h0 || out_illegal !== 1'b0) begin
      bad++;
      $display("FAIL R1: actual v=%b r=%h i=%b expected 0 0 0", out_valid, out_result, out_illegal);
    end
    rst = 1'b0;

    // R3 R4 R5: logic group with reserved tail
    for (int f = 0; f < 16; f++)
      for (int p = 0; p < 6; p++)
        drive(12'h020 + 12'(f), pats[p], pats[(p + 3) % 6]);

    // R7 R8 R9 R10: shift group with boundary amounts
    for (int f = 0; f < 8; f++)
      for (int p = 1; p < 6; p++)
        for (int a = 0; a < 9; a++)
          drive(12'h030 + 12'(f), pats[p], amts[a]);

    // R5: codes outside both groups
    drive(12'h000, 32'hDEAD_BEEF, 32'h1);
    drive(12'h038, 32'hDEAD_BEEF, 32'h1);
    drive(12'h12A, 32'hDEAD_BEEF, 32'h1);
    drive(12'hFFF, 32'hDEAD_BEEF, 32'h1);
    drive(12'h010, 32'hDEAD_BEEF, 32'h1);

    // random sweep over legal codes
    for (int i = 0; i < 200; i++) begin
      logic [11:0] op;
      op = ($urandom % 2) ? (12'h020 + 12'($urandom % 10)) : (12'h030 + 12'($urandom % 8));
      drive(op, $urandom, ($urandom % 3 == 0) ? $urandom : ($urandom % 40));
    end

    // last legal op, then idle
    drive(12'h021, 32'hA5A5_0000, 32'h0000_5A5A);
    @(negedge clk);
    in_valid = 1'b0;
    xop = 12'hFFF;
    src_b = 32'h1;
    src_c = 32'h2;
    @(negedge clk);
    held_r = out_result;
    held_i = out_illegal;
    repeat (3) @(negedge clk);
    // R11: idle cycles produce no valid and keep the last result
    total++;
    if (out_valid !== 1'b0 || out_result !== held_r || out_illegal !== held_i || held_r !== 32'hA5A5_5A5A) begin
      bad++;
      $display("FAIL R11: actual v=%b r=%h i=%b expected v=0 r=a5a55a5a i=0",
               out_valid, out_result, out_illegal);
    end
    // R2: every queued operation came back
    total++;
    if (sbq.size() != 0) begin
      bad++;
      $display("FAIL R2: actual pending=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule